// File: doc/BRIEF.md
# FMA Special-Operand Result Selector

This combinational block sits in front of the arithmetic datapath of a single-precision fused multiply-add that computes `acc + a*b`. A classifier upstream supplies a class code, a sign and the raw 32-bit encoding for each of the three operands. From these the selector decides whether the result is fixed by the operand classes alone, such as a NaN, an infinity, an invalid combination or an untouched accumulator, or whether the full multiply-add has to run.

When the result is fixed, the block raises the bypass flag and drives the final 32-bit result. If the case is an invalid operation it also raises the invalid flag. Otherwise it raises the proceed flag so that the arithmetic path takes over. NaN propagation follows a fixed priority across the three operands. An infinite product is returned without checking the sign of an infinite accumulator.

Top module: `fma_special_sel`

## Requirements
- R1: Class codes are 3 bits: 0 signalling NaN, 1 quiet NaN, 2 infinity, 3 zero, 4 normal, 5 denormal. A signalling NaN accumulator wins over every other case. It gives bypass, raises invalid, and returns the accumulator encoding with fraction bit 22 set.
- R2: If the accumulator is not a signalling NaN and the second multiplicand is one, the second multiplicand is returned with bit 22 set and invalid raised. This holds even when the first multiplicand is also a signalling NaN. Only if the second is not a signalling NaN does a signalling NaN in the first multiplicand give the same treatment to the first.
- R3: With no signalling NaN anywhere, a quiet NaN multiplicand is returned unchanged without invalid. The second multiplicand is chosen before the first. A quiet NaN accumulator is never returned while a multiplicand is a NaN.
- R4: Infinity times zero, in either order, returns the accumulator unchanged if it is a quiet NaN. Otherwise it raises invalid and returns 0x7FC00000.
- R5: Infinity times infinity, or infinity times a normal or denormal value, returns a quiet NaN accumulator unchanged. Otherwise it returns infinity whose sign is the XOR of the multiplicand signs, whatever the accumulator's infinity sign.
- R6: A zero times a zero, normal or denormal value returns infinity with the accumulator's sign when the accumulator is infinite. Otherwise it returns the accumulator encoding unchanged, without invalid.
- R7: With both multiplicands normal or denormal, a quiet NaN accumulator is returned unchanged, and an infinite accumulator gives infinity with the accumulator's sign.
- R8: Proceed is high exactly when both multiplicands are normal or denormal and the accumulator is zero, normal or denormal. Proceed and bypass are never both high, and one of them is always high. With proceed high, the result is 0 and invalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mul_a_cls | input | 3 | Class code of the first multiplicand |
| mul_a_sgn | input | 1 | Sign of the first multiplicand |
| mul_a_raw | input | 32 | Encoding of the first multiplicand |
| mul_b_cls | input | 3 | Class code of the second multiplicand |
| mul_b_sgn | input | 1 | Sign of the second multiplicand |
| mul_b_raw | input | 32 | Encoding of the second multiplicand |
| acc_cls | input | 3 | Class code of the accumulator |
| acc_sgn | input | 1 | Sign of the accumulator |
| acc_raw | input | 32 | Encoding of the accumulator |
| byp_valid | output | 1 | Result is fixed by the operand classes |
| byp_result | output | 32 | Fixed result, zero when not bypassing |
| invalid_op | output | 1 | Invalid operation detected |
| run_datapath | output | 1 | Arithmetic path must compute the result |

## Verification
Two rules can claim the same operand set in the same evaluation. One is NaN propagation from the multiplicands. The other is the return of a quiet NaN accumulator, which is the fallback for infinite, zero or finite products. The bench provokes the overlap by pairing a quiet NaN accumulator with quiet and signalling NaN multiplicands, and with infinity-times-zero products. It judges the outcome by which encoding reaches the result and by whether invalid is raised.

// File: rtl/fma_special_pkg.sv
// Shared types and constants for the FMA special-operand selector.
// Assumes IEEE single-precision layout (1 sign, 8 exponent, 23 fraction bits).
package fma_special_pkg;
    localparam int FP_W      = 32;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = FP_W - EXP_W - 1;
    localparam int QUIET_BIT = FRAC_W - 1;
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_SNAN  = 3'd0,
        CL_QNAN  = 3'd1,
        CL_INF   = 3'd2,
        CL_ZERO  = 3'd3,
        CL_NORM  = 3'd4,
        CL_DNORM = 3'd5
    } opclass_e;

    localparam logic [FP_W-1:0] INF_MAG     = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [FP_W-1:0] DEFAULT_NAN = INF_MAG | (FP_W'(1) << QUIET_BIT);

    function automatic logic [FP_W-1:0] quieten(input logic [FP_W-1:0] v);
        return v | (FP_W'(1) << QUIET_BIT);
    endfunction

    function automatic logic [FP_W-1:0] signed_inf(input logic s);
        return INF_MAG | ({s, {(FP_W-1){1'b0}}});
    endfunction

    function automatic logic is_finite_nz(input opclass_e c);
        return (c == CL_NORM) || (c == CL_DNORM);
    endfunction
endpackage

// File: rtl/fma_nan_pick.sv
// NaN propagation across the three operands.
// Priority: accumulator sNaN, mult-b sNaN, mult-a sNaN, mult-b qNaN, mult-a qNaN.
// Assumes class codes are already valid; does not look at quiet NaN accumulator.
module fma_nan_pick
    import fma_special_pkg::*;
(
    input  opclass_e          a_cls,
    input  logic [FP_W-1:0]   a_raw,
    input  opclass_e          b_cls,
    input  logic [FP_W-1:0]   b_raw,
    input  opclass_e          c_cls,
    input  logic [FP_W-1:0]   c_raw,
    output logic              hit,
    output logic              inv,
    output logic [FP_W-1:0]   res
);
    // Fixed-priority selection of the propagated NaN.
    always_comb begin
        hit = 1'b1;
        inv = 1'b1;
        res = '0;
        if (c_cls == CL_SNAN) begin
            res = quieten(c_raw);
        end else if (b_cls == CL_SNAN) begin
            res = quieten(b_raw);
        end else if (a_cls == CL_SNAN) begin
            res = quieten(a_raw);
        end else if (b_cls == CL_QNAN) begin
            inv = 1'b0;
            res = b_raw;
        end else if (a_cls == CL_QNAN) begin
            inv = 1'b0;
            res = a_raw;
        end else begin
            hit = 1'b0;
            inv = 1'b0;
        end
    end
endmodule

// File: rtl/fma_prod_case.sv
// Product-class case analysis once no multiplicand or sNaN accumulator NaN applies.
// Assumes multiplicands are INF/ZERO/NORM/DNORM and accumulator is not sNaN;
// outputs for other inputs are don't-care and gated by the top.
module fma_prod_case
    import fma_special_pkg::*;
(
    input  opclass_e          a_cls,
    input  logic              a_sgn,
    input  opclass_e          b_cls,
    input  logic              b_sgn,
    input  opclass_e          c_cls,
    input  logic              c_sgn,
    input  logic [FP_W-1:0]   c_raw,
    output logic              hit,
    output logic              inv,
    output logic [FP_W-1:0]   res,
    output logic              proceed
);
    logic a_inf, b_inf, a_zero, b_zero, c_qnan, c_inf;

    // Decode the class pairs used below.
    always_comb begin
        a_inf  = (a_cls == CL_INF);
        b_inf  = (b_cls == CL_INF);
        a_zero = (a_cls == CL_ZERO);
        b_zero = (b_cls == CL_ZERO);
        c_qnan = (c_cls == CL_QNAN);
        c_inf  = (c_cls == CL_INF);
    end

    // Select the fixed result for each product class.
    always_comb begin
        hit     = 1'b1;
        inv     = 1'b0;
        res     = '0;
        proceed = 1'b0;
        if ((a_inf && b_zero) || (a_zero && b_inf)) begin
            if (c_qnan) res = c_raw;
            else begin
                inv = 1'b1;
                res = DEFAULT_NAN;
            end
        end else if (a_inf || b_inf) begin
            res = c_qnan ? c_raw : signed_inf(a_sgn ^ b_sgn);
        end else if (a_zero || b_zero) begin
            res = c_inf ? signed_inf(c_sgn) : c_raw;
        end else if (c_qnan) begin
            res = c_raw;
        end else if (c_inf) begin
            res = signed_inf(c_sgn);
        end else begin
            hit     = 1'b0;
            proceed = 1'b1;
        end
    end
endmodule

// File: rtl/fma_special_sel.sv
// Top of the FMA special-operand selector: merges NaN propagation with the
// product case analysis and drives bypass, invalid and proceed.
// Purely combinational; the caller registers the outputs.
module fma_special_sel
    import fma_special_pkg::*;
(
    input  logic [2:0]  mul_a_cls,
    input  logic        mul_a_sgn,
    input  logic [31:0] mul_a_raw,
    input  logic [2:0]  mul_b_cls,
    input  logic        mul_b_sgn,
    input  logic [31:0] mul_b_raw,
    input  logic [2:0]  acc_cls,
    input  logic        acc_sgn,
    input  logic [31:0] acc_raw,
    output logic        byp_valid,
    output logic [31:0] byp_result,
    output logic        invalid_op,
    output logic        run_datapath
);
    opclass_e a_c, b_c, c_c;
    logic            n_hit, n_inv, p_hit, p_inv, p_go;
    logic [FP_W-1:0] n_res, p_res;

    // Type the raw class inputs.
    always_comb begin
        a_c = opclass_e'(mul_a_cls);
        b_c = opclass_e'(mul_b_cls);
        c_c = opclass_e'(acc_cls);
    end

    fma_nan_pick u_nan (
        .a_cls(a_c), .a_raw(mul_a_raw),
        .b_cls(b_c), .b_raw(mul_b_raw),
        .c_cls(c_c), .c_raw(acc_raw),
        .hit(n_hit), .inv(n_inv), .res(n_res)
    );

    fma_prod_case u_prod (
        .a_cls(a_c), .a_sgn(mul_a_sgn),
        .b_cls(b_c), .b_sgn(mul_b_sgn),
        .c_cls(c_c), .c_sgn(acc_sgn), .c_raw(acc_raw),
        .hit(p_hit), .inv(p_inv), .res(p_res), .proceed(p_go)
    );

    // NaN propagation outranks every product case.
    always_comb begin
        byp_valid    = n_hit | p_hit;
        byp_result   = n_hit ? n_res : p_res;
        invalid_op   = n_hit ? n_inv : p_inv;
        run_datapath = ~n_hit & p_go;
    end
endmodule

// File: rtl/fma_special_sel_chk.sv
// Checker for fma_special_sel: cross-checks outputs against operand classes.
module fma_special_sel_chk (
    input logic [2:0]  mul_a_cls,
    input logic [2:0]  mul_b_cls,
    input logic [2:0]  acc_cls,
    input logic [31:0] acc_raw,
    input logic        byp_valid,
    input logic [31:0] byp_result,
    input logic        invalid_op,
    input logic        run_datapath
);
    logic a_fin, b_fin, c_ok;

    // Operand-set conditions for the proceed path.
    always_comb begin
        a_fin = (mul_a_cls == 3'd4) || (mul_a_cls == 3'd5);
        b_fin = (mul_b_cls == 3'd4) || (mul_b_cls == 3'd5);
        c_ok  = (acc_cls >= 3'd3) && (acc_cls <= 3'd5);
    end

    // Immediate checks on the settled outputs.
    always_comb begin
        a_r8_one_path: assert (byp_valid ^ run_datapath);
        a_r8_proceed_cond: assert (run_datapath == (a_fin && b_fin && c_ok));
        a_r8_quiet_on_run: assert (!run_datapath || (!invalid_op && byp_result == 32'd0));
        a_r1_acc_snan: assert (acc_cls != 3'd0 ||
                               (invalid_op && byp_result == (acc_raw | 32'h0040_0000)));
        a_r4_invalid_is_qnan: assert (!invalid_op || byp_result[30:22] == 9'h1FF);
        a_r6_zero_prod: assert (!((mul_a_cls == 3'd3 || mul_b_cls == 3'd3) &&
                                  mul_a_cls >= 3'd3 && mul_b_cls >= 3'd3 &&
                                  acc_cls != 3'd0 && acc_cls != 3'd2) ||
                                (byp_result == acc_raw && !invalid_op));
    end
endmodule

bind fma_special_sel fma_special_sel_chk u_chk (
    .mul_a_cls(mul_a_cls), .mul_b_cls(mul_b_cls), .acc_cls(acc_cls),
    .acc_raw(acc_raw), .byp_valid(byp_valid), .byp_result(byp_result),
    .invalid_op(invalid_op), .run_datapath(run_datapath)
);

// File: tb/tb_fma_special_sel.sv
// Directed bench for fma_special_sel: one task per scenario.
module tb_fma_special_sel;
    localparam logic [2:0] SN = 3'd0, QN = 3'd1, IN = 3'd2, ZE = 3'd3, NO = 3'd4, DN = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0]  a_cls, b_cls, c_cls;
    logic        a_sgn, b_sgn, c_sgn;
    logic [31:0] a_raw, b_raw, c_raw;
    logic        byp_valid, invalid_op, run_datapath;
    logic [31:0] byp_result;

    int tests = 0;
    int fails = 0;

    fma_special_sel dut (
        .mul_a_cls(a_cls), .mul_a_sgn(a_sgn), .mul_a_raw(a_raw),
        .mul_b_cls(b_cls), .mul_b_sgn(b_sgn), .mul_b_raw(b_raw),
        .acc_cls(c_cls), .acc_sgn(c_sgn), .acc_raw(c_raw),
        .byp_valid(byp_valid), .byp_result(byp_result),
        .invalid_op(invalid_op), .run_datapath(run_datapath)
    );

    task automatic drive(input logic [2:0] ac, input logic [31:0] ar,
                         input logic [2:0] bc, input logic [31:0] br,
                         input logic [2:0] cc, input logic [31:0] cr);
        @(negedge clk);
        a_cls = ac; a_raw = ar; a_sgn = ar[31];
        b_cls = bc; b_raw = br; b_sgn = br[31];
        c_cls = cc; c_raw = cr; c_sgn = cr[31];
        #1;
    endtask

    task automatic expect_out(input string req, input logic v, input logic [31:0] r,
                              input logic inv, input logic go);
        tests++;
        if (byp_valid !== v || byp_result !== r || invalid_op !== inv || run_datapath !== go) begin
            fails++;
            $display("FAIL %s: got v=%b r=%h inv=%b go=%b, expected v=%b r=%h inv=%b go=%b",
                     req, byp_valid, byp_result, invalid_op, run_datapath, v, r, inv, go);
        end
    endtask

    task automatic t_reset_state;
        drive(ZE, 32'h0, ZE, 32'h0, ZE, 32'h0);
        expect_out("R6 idle", 1, 32'h0, 0, 0);
    endtask

    task automatic t_acc_snan; // R1
        drive(QN, 32'h7FC0_0011, SN, 32'h7F80_0002, SN, 32'hFF80_0005);
        expect_out("R1", 1, 32'hFFC0_0005, 1, 0);
        drive(NO, 32'h3F80_0000, NO, 32'h4000_0000, SN, 32'h7F80_0001);
        expect_out("R1 finite", 1, 32'h7FC0_0001, 1, 0);
    endtask

    task automatic t_mul_snan; // R2
        drive(SN, 32'h7F80_0003, SN, 32'hFF80_0009, QN, 32'h7FC0_0000);
        expect_out("R2 b first", 1, 32'hFFC0_0009, 1, 0);
        drive(SN, 32'h7F80_0003, QN, 32'h7FC0_0007, NO, 32'h3F80_0000);
        expect_out("R2 a", 1, 32'h7FC0_0003, 1, 0);
    endtask

    task automatic t_mul_qnan; // R3
        drive(QN, 32'h7FC0_0001, QN, 32'hFFC0_0002, QN, 32'h7FC0_0033);
        expect_out("R3 b first", 1, 32'hFFC0_0002, 0, 0);
        drive(QN, 32'h7FC0_0001, IN, 32'h7F80_0000, QN, 32'h7FC0_0033);
        expect_out("R3 a over acc", 1, 32'h7FC0_0001, 0, 0);
    endtask

    task automatic t_inf_zero; // R4
        drive(IN, 32'hFF80_0000, ZE, 32'h0, NO, 32'h3F80_0000);
        expect_out("R4 invalid", 1, 32'h7FC0_0000, 1, 0);
        drive(ZE, 32'h8000_0000, IN, 32'h7F80_0000, QN, 32'h7FC0_0044);
        expect_out("R4 acc qnan", 1, 32'h7FC0_0044, 0, 0);
    endtask

    task automatic t_inf_prod; // R5
        drive(IN, 32'hFF80_0000, NO, 32'h3F80_0000, IN, 32'hFF80_0000);
        expect_out("R5 sign xor", 1, 32'hFF80_0000, 0, 0);
        drive(IN, 32'hFF80_0000, DN, 32'h8000_0001, IN, 32'hFF80_0000);
        expect_out("R5 acc sign ignored", 1, 32'h7F80_0000, 0, 0);
        drive(IN, 32'h7F80_0000, IN, 32'h7F80_0000, QN, 32'hFFC0_0001);
        expect_out("R5 acc qnan", 1, 32'hFFC0_0001, 0, 0);
    endtask

    task automatic t_zero_prod; // R6
        drive(ZE, 32'h0, NO, 32'h4000_0000, IN, 32'hFF80_0000);
        expect_out("R6 acc inf", 1, 32'hFF80_0000, 0, 0);
        drive(DN, 32'h0000_0010, ZE, 32'h8000_0000, DN, 32'h8000_0003);
        expect_out("R6 acc kept", 1, 32'h8000_0003, 0, 0);
    endtask

    task automatic t_finite_prod; // R7
        drive(NO, 32'h3F80_0000, DN, 32'h0000_0001, QN, 32'h7FC1_2345);
        expect_out("R7 acc qnan", 1, 32'h7FC1_2345, 0, 0);
        drive(NO, 32'h3F80_0000, NO, 32'hC000_0000, IN, 32'h7F80_0000);
        expect_out("R7 acc inf", 1, 32'h7F80_0000, 0, 0);
    endtask

    task automatic t_proceed; // R8
        drive(NO, 32'h3F80_0000, NO, 32'h4000_0000, ZE, 32'h0);
        expect_out("R8 zero acc", 0, 32'h0, 0, 1);
        drive(DN, 32'h0000_0005, NO, 32'hC000_0000, DN, 32'h0000_0007);
        expect_out("R8 denorm", 0, 32'h0, 0, 1);
    endtask

    initial begin
        a_cls = ZE; b_cls = ZE; c_cls = ZE;
        a_raw = '0; b_raw = '0; c_raw = '0;
        a_sgn = 0; b_sgn = 0; c_sgn = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_acc_snan();
        t_mul_snan();
        t_mul_qnan();
        t_inf_zero();
        t_inf_prod();
        t_zero_prod();
        t_finite_prod();
        t_proceed();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule